// File: doc/BRIEF.md
# Timer Capture/Compare Channel

One channel of a 16-bit timer. A free-running counter outside the block supplies its value and an end-of-period pulse. The channel can be inactive and hold a chosen idle level on its output pin, or it can run in one of three modes. In input capture it latches the counter on a chosen pin edge. In unbuffered output compare/PWM it acts on the pin when the counter equals the compare value. In buffered output compare/PWM a new compare value takes effect only at the end of a counter period.

Software sees three byte registers through simple read and write strobes. Address 0 holds the control and status byte. Address 1 holds the high byte of the capture/compare value and address 2 its low byte. Every capture and every compare match sets an event flag. When interrupts are enabled, the set flag drives an interrupt request. The flag clears only through an interlocked read-then-write sequence, so an event that arrives during the sequence is never lost.

Top module: `tmr_chan`

## Requirements
- R1: After reset, the control byte reads 0x00, `pin_out` is 1 and `irq` is 0.
- R2: The event flag (control bit 7) goes to 0 only when a write of a 0 to bit 7 at address 0 follows a read of address 0 that was made while the flag was 1. A write of 0 without that prior read leaves the flag set.
- R3: If a capture or compare event occurs after the arming read and before the write of 0, the write leaves the flag set.
- R4: Writing 1 to bit 7 never changes the flag.
- R5: `irq` equals the event flag ANDed with the interrupt enable (control bit 6), which is read/write and resets to 0.
- R6: The buffered-mode bit (control bit 5) is stored only when parameter CHAN_IDX is 0. On any other channel it reads 0 and ignores writes.
- R7: When the edge/level field (control bits 3:2) is 00, the channel is inactive and `pin_out` follows the inverse of mode bit A (control bit 4): 1 drives the pin low, 0 drives it high. The change shows two clocks after the control write.
- R8: In capture mode (field not 00, bits 5 and 4 both 0), the field selects the edge of `pin_in`: 01 rising, 10 falling, 11 either. On the selected edge the block copies `cnt_val` into the value register and sets the flag, one clock after the pin changes. Edges that are not selected have no effect.
- R9: In compare mode (field not 00 and bit 4 or bit 5 set), `cnt_val` equal to the active compare value sets the flag in the same clock. The field then chooses the pin action: 01 toggles, 10 clears, 11 sets.
- R10: In compare mode, a `cnt_ovf` pulse without a match drives the pin high when the field is 10 and low when it is 11.
- R11: In buffered mode, a completed compare write goes to a shadow register. The shadow is copied into the active compare value on `cnt_ovf`. Reads of addresses 1 and 2 return the active value.
- R12: A write to address 1 stages the high byte and blocks compare matches. The following write to address 2 commits both bytes and lets matching resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | 16 | Free-running counter value |
| cnt_ovf | input | 1 | High during the last count of a period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address (0 control, 1 high byte, 2 low byte) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| pin_in | input | 1 | Capture input pin, already synchronous |
| pin_out | output | 1 | Compare/PWM output pin |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that read and write strobes never come in the same clock. They also assume the mode bits change only while the counter is held. The stimulus meets both conditions: each bus operation sits in its own clock, and mode writes happen only while the bench drives the counter by hand. Compare writes made while the counter runs free can still meet an overflow. Both the block and the reference model define that case the same way: the old shadow value moves to active and the new value goes to the shadow.

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CHAN_IDX = 0,
  parameter int CW = 16,
  localparam int BW = 8,
  localparam int HW = CW - BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_ovf,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] rdata,
  input  logic          pin_in,
  output logic          pin_out,
  output logic          irq
);

  logic          flag, armed, ie, msb, msa, inhibit, pin_q, pin_r;
  logic [1:0]    els;
  logic [CW-1:0] cval, shadow;
  logic [HW-1:0] hi_hold;
  logic          active, cap_mode, cmp_mode, cap_evt, match, evt;
  logic          wr_ctl, wr_hi, wr_lo, rd_ctl, clr_ok;

  assign active   = |els;
  assign cap_mode = active & ~msb & ~msa;
  assign cmp_mode = active & (msa | msb);
  assign cap_evt  = cap_mode & ((els[0] & pin_in & ~pin_q) | (els[1] & ~pin_in & pin_q));
  assign match    = cmp_mode & ~inhibit & (cnt_val == cval);
  assign evt      = cap_evt | match;

  assign wr_ctl = wr_en & (addr == 2'd0);
  assign wr_hi  = wr_en & (addr == 2'd1);
  assign wr_lo  = wr_en & (addr == 2'd2);
  assign rd_ctl = rd_en & (addr == 2'd0);
  assign clr_ok = wr_ctl & ~wdata[7] & armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (evt) flag <= 1'b1;
      else if (clr_ok) flag <= 1'b0;
      if (evt || wr_ctl) armed <= 1'b0;
      else if (rd_ctl && flag) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie  <= 1'b0;
      msa <= 1'b0;
      els <= 2'b00;
    end else if (wr_ctl) begin
      ie  <= wdata[6];
      msa <= wdata[4];
      els <= wdata[3:2];
    end
  end

  generate
    if (CHAN_IDX == 0) begin : g_buf
      logic msb_r;
      always_ff @(posedge clk) begin
        if (!rst_n) msb_r <= 1'b0;
        else if (wr_ctl) msb_r <= wdata[5];
      end
      assign msb = msb_r;
    end else begin : g_nobuf
      assign msb = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cval    <= '0;
      shadow  <= '0;
      hi_hold <= '0;
      inhibit <= 1'b0;
    end else begin
      if (cnt_ovf && msb) cval <= shadow;
      if (wr_hi) begin
        hi_hold <= wdata[HW-1:0];
        inhibit <= 1'b1;
      end
      if (wr_lo) begin
        inhibit <= 1'b0;
        if (msb) shadow <= {hi_hold, wdata};
        else     cval   <= {hi_hold, wdata};
      end
      if (cap_evt) cval <= cnt_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      pin_r <= 1'b1;
    end else begin
      pin_q <= pin_in;
      if (!active) pin_r <= ~msa;
      else if (cmp_mode) begin
        if (match) begin
          case (els)
            2'b01:   pin_r <= ~pin_r;
            2'b10:   pin_r <= 1'b0;
            default: pin_r <= 1'b1;
          endcase
        end else if (cnt_ovf && els == 2'b10) pin_r <= 1'b1;
        else if (cnt_ovf && els == 2'b11) pin_r <= 1'b0;
      end
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {flag, ie, msb, msa, els, 2'b00};
      2'd1:    rdata = cval[CW-1:BW];
      2'd2:    rdata = cval[BW-1:0];
      default: rdata = '0;
    endcase
  end

  assign pin_out = pin_r;
  assign irq     = flag & ie;

endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [1:0] addr,
  input logic       wbit,
  input logic [7:0] rdata,
  input logic       irq,
  input logic       pin_out,
  input logic       flag,
  input logic       armed,
  input logic       inhibit,
  input logic       msa,
  input logic [1:0] els,
  input logic       cmp_mode
);

  assert_irq_view_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0) |-> (irq == (rdata[7] && rdata[6])));

  assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag) && !($past(wr_en) && $past(addr) == 2'd0 && !$past(wbit))) |-> flag);

  assert_clear_needs_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> ($past(armed) && $past(wr_en) && $past(addr) == 2'd0 && !$past(wbit)));

  assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (els == 2'b00) |=> (pin_out == !$past(msa)));

  assert_inhibit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode && inhibit && !flag) |=> !flag);

endmodule

bind tmr_chan tmr_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wbit(wdata[7]), .rdata(rdata), .irq(irq), .pin_out(pin_out), .flag(flag),
  .armed(armed), .inhibit(inhibit), .msa(msa), .els(els), .cmp_mode(cmp_mode)
);

// File: tb/tmr_chan_tb.sv
`timescale 1ns/1ps
module tmr_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_val = '0;
  logic        cnt_ovf = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, rdata1;
  logic        pin_in = 1'b0;
  logic        pin_out, irq, pin_out1, irq1;
  logic        run = 1'b0;
  logic [15:0] top = 16'd63;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_chan #(.CHAN_IDX(0)) u_dut (.clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pin_in(pin_in), .pin_out(pin_out), .irq(irq));
  tmr_chan #(.CHAN_IDX(1)) u_dut1 (.clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata1),
    .pin_in(pin_in), .pin_out(pin_out1), .irq(irq1));

  // behavioural reference model of channel 0
  bit m_flag, m_arm, m_ie, m_b, m_a, m_hold, m_pin, m_prev;
  int m_els;
  int m_val, m_buf, m_hi;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flag = 0; m_arm = 0; m_ie = 0; m_b = 0; m_a = 0; m_hold = 0;
      m_pin = 1; m_prev = 0; m_els = 0; m_val = 0; m_buf = 0; m_hi = 0;
    end else begin
      bit act, capm, cmpm, up, dn, cap, mt, ev, wc, np;
      int nv;
      act  = (m_els != 0);
      capm = act && !m_b && !m_a;
      cmpm = act && (m_a || m_b);
      up   = pin_in && !m_prev;
      dn   = !pin_in && m_prev;
      cap  = capm && ((m_els == 1 && up) || (m_els == 2 && dn) || (m_els == 3 && (up || dn)));
      mt   = cmpm && !m_hold && (int'(cnt_val) == m_val);
      ev   = cap || mt;
      wc   = wr_en && addr == 0;
      np = m_pin;
      if (!act) np = !m_a;
      else if (cmpm) begin
        if (mt) np = (m_els == 1) ? !m_pin : (m_els == 3);
        else if (cnt_ovf && m_els == 2) np = 1;
        else if (cnt_ovf && m_els == 3) np = 0;
      end
      m_pin = np;
      nv = m_val;
      if (cnt_ovf && m_b) nv = m_buf;
      if (wr_en && addr == 2) begin
        if (m_b) m_buf = m_hi * 256 + int'(wdata);
        else nv = m_hi * 256 + int'(wdata);
        m_hold = 0;
      end
      if (wr_en && addr == 1) begin m_hi = int'(wdata); m_hold = 1; end
      if (cap) nv = int'(cnt_val);
      m_val = nv;
      if (ev) begin m_flag = 1; m_arm = 0; end
      else begin
        if (wc && !wdata[7] && m_arm) m_flag = 0;
        if (wc) m_arm = 0;
        else if (rd_en && addr == 0 && m_flag) m_arm = 1;
      end
      if (wc) begin
        m_ie = wdata[6]; m_b = wdata[5]; m_a = wdata[4]; m_els = int'(wdata[3:2]);
      end
      m_prev = pin_in;
    end
  end

  function automatic logic [7:0] m_read(input logic [1:0] a);
    logic [15:0] v;
    v = m_val[15:0];
    case (a)
      2'd0: return {m_flag, m_ie, m_b, m_a, m_els[1:0], 2'b00};
      2'd1: return v[15:8];
      2'd2: return v[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({7'd0, pin_out}, {7'd0, m_pin}, "R7 R9 R10 pin model");
      chk({7'd0, irq}, {7'd0, m_flag && m_ie}, "R5 irq model");
    end
  end

  task automatic step();
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    if (run) begin
      cnt_val = (cnt_val == top) ? 16'd0 : cnt_val + 16'd1;
      cnt_ovf = (cnt_val == top);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step();
    wr_en = 1; addr = a; wdata = d;
  endtask

  task automatic rd_exp(input logic [1:0] a, input logic [7:0] exp, input string tag);
    step();
    rd_en = 1; addr = a;
    #1 chk(rdata, exp, tag);
  endtask

  task automatic rd_m(input logic [1:0] a);
    step();
    rd_en = 1; addr = a;
    #1 chk(rdata, m_read(a), "R2 R11 read model");
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    rd_exp(0, 8'h00, "R1 ctrl");
    chk({7'd0, pin_out}, 8'h01, "R1 pin");
    chk({7'd0, irq}, 8'h00, "R1 irq");

    wr(0, 8'h10); idle(2); chk({7'd0, pin_out}, 8'h00, "R7 low");
    wr(0, 8'h00); idle(2); chk({7'd0, pin_out}, 8'h01, "R7 high");

    cnt_val = 16'h1234;
    wr(0, 8'h44); idle(1);
    pin_in = 1; idle(1);
    rd_exp(1, 8'h12, "R8 rise hi");
    rd_exp(2, 8'h34, "R8 rise lo");
    chk({7'd0, irq}, 8'h01, "R5 irq set");
    rd_exp(0, 8'hC4, "R2 flag set");
    wr(0, 8'h44); idle(1);
    rd_exp(0, 8'h44, "R2 cleared");
    chk({7'd0, irq}, 8'h00, "R5 irq clear");

    cnt_val = 16'h5555; pin_in = 0; idle(2);
    rd_exp(1, 8'h12, "R8 falling ignored");
    rd_exp(0, 8'h44, "R8 no flag");
    cnt_val = 16'h2222; pin_in = 1; idle(2);
    rd_exp(0, 8'hC4, "R8 second rise");
    wr(0, 8'hC4); idle(1);
    chk({7'd0, irq}, 8'h01, "R4 write one");
    wr(0, 8'h44); idle(1);
    chk({7'd0, irq}, 8'h01, "R2 no read");

    wr(0, 8'h4C); idle(1);
    rd_exp(0, 8'hCC, "R3 arm");
    idle(1);
    cnt_val = 16'h3333; pin_in = 0;
    wr(0, 8'h4C); idle(1);
    chk({7'd0, irq}, 8'h01, "R3 event wins");
    rd_exp(1, 8'h33, "R8 both edges");
    rd_exp(0, 8'hCC, "R2 arm again");
    wr(0, 8'h4C); idle(1);
    chk({7'd0, irq}, 8'h00, "R2 clear");

    cnt_val = 16'h0000;
    wr(1, 8'h00); wr(2, 8'h10);
    wr(0, 8'h54); idle(1);
    cnt_val = 16'h0010; idle(1);
    chk({7'd0, pin_out}, 8'h00, "R9 toggle");
    chk({7'd0, irq}, 8'h01, "R9 flag");
    cnt_val = 16'h0011; idle(1);
    chk({7'd0, pin_out}, 8'h00, "R9 single toggle");
    rd_exp(0, 8'hD4, "R9 ctrl");
    wr(0, 8'h54); idle(1);

    wr(0, 8'h58); idle(1);
    cnt_ovf = 1; idle(1); cnt_ovf = 0;
    chk({7'd0, pin_out}, 8'h01, "R10 ovf high");
    cnt_val = 16'h0010; idle(1); cnt_val = 16'h0011;
    chk({7'd0, pin_out}, 8'h00, "R9 clear");
    wr(0, 8'h5C); idle(1);
    cnt_val = 16'h0010; idle(1); cnt_val = 16'h0011;
    chk({7'd0, pin_out}, 8'h01, "R9 set");
    cnt_ovf = 1; idle(1); cnt_ovf = 0;
    chk({7'd0, pin_out}, 8'h00, "R10 ovf low");
    rd_exp(0, 8'hDC, "R9 flag");
    wr(0, 8'h5C); idle(1);

    wr(1, 8'h00); idle(1);
    cnt_val = 16'h0010; idle(1); cnt_val = 16'h0011;
    chk({7'd0, irq}, 8'h00, "R12 inhibited");
    chk({7'd0, pin_out}, 8'h00, "R12 pin held");
    wr(2, 8'h10); idle(1);
    cnt_val = 16'h0010; idle(1); cnt_val = 16'h0011;
    chk({7'd0, irq}, 8'h01, "R12 resumed");
    chk({7'd0, pin_out}, 8'h01, "R12 pin set");
    rd_exp(0, 8'hDC, "R12 ctrl");
    wr(0, 8'h5C); idle(1);

    wr(0, 8'h68); idle(1);
    wr(1, 8'h00); wr(2, 8'h20); idle(1);
    rd_exp(2, 8'h10, "R11 active kept");
    cnt_val = 16'h0020; idle(1); cnt_val = 16'h0021;
    chk({7'd0, irq}, 8'h00, "R11 no early match");
    cnt_ovf = 1; idle(1); cnt_ovf = 0;
    rd_exp(2, 8'h20, "R11 transferred");
    cnt_val = 16'h0020; idle(1); cnt_val = 16'h0021;
    chk({7'd0, irq}, 8'h01, "R11 match");
    chk({7'd0, pin_out}, 8'h00, "R11 pin");

    step(); rd_en = 1; addr = 0;
    #1 chk({7'd0, rdata[5]}, 8'h01, "R6 chan0 bit");
    chk({7'd0, rdata1[5]}, 8'h00, "R6 chan1 bit");

    rd_m(0); wr(0, 8'h68);
    cnt_val = 16'd0; run = 1;
    idle(150);
    wr(1, 8'h00); wr(2, 8'h30);
    idle(150);
    for (int k = 0; k < 20; k++) begin
      rd_m(0); idle(3); wr(0, 8'h68); rd_m(2); idle(7);
    end
    wr(1, 8'h00); idle(5); wr(2, 8'h08);
    idle(200);
    run = 0;
    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule